// File: doc/BRIEF.md
# Split-Access 32-bit Interval Timer

This block is a timer peripheral for a processor with a 16-bit data path. A 32-bit counter advances by one on every clock while the timer is running. When the count matches a programmed 32-bit limit, the timer records a timeout and can raise an interrupt. Software picks the mode. In repeating mode the counter wraps to zero and keeps going. In single mode the timer halts after the first timeout.

Every 32-bit quantity is seen as two 16-bit words. The limit is written and read through a low word and a high word. The live count is never read directly, because its two halves would come from different moments. Instead, a write to either snapshot word copies the whole count into a holding register in one cycle. Software then reads the two held halves at leisure.

The register port is a plain synchronous write strobe with an address and data. Read data is combinational from the address, and reading has no side effect. There is no stream traffic, so no handshake is involved.

Top module: `tmr16_interval`

## Requirements
- R1: After reset the counter is 0 and stopped. The flag, both control bits and the snapshot are 0, `irq` is low, and the limit words read back the `RESET_PERIOD` parameter (default all ones).
- R2: While running, the count rises by one each clock. The timeout flag (status address 0, bit 0) becomes visible period+1 clocks after the edge that accepted the start write.
- R3: In repeating mode (control bit 1 = 1), the counter returns to 0 on a timeout and stays running. Timeouts therefore recur every period+1 clocks.
- R4: In single mode (control bit 1 = 0), a timeout clears the running indicator (status bit 1) and leaves the count at 0.
- R5: `irq` is high exactly while the timeout flag is set and interrupt enable (control bit 0) is 1.
- R6: Any write to status address 0 clears the flag. If a new timeout lands on the same edge as that write, the flag stays set.
- R7: Control address 1 behaves as follows:
  - Bits 0 and 1 are stored and read back.
  - Bit 2 (start) and bit 3 (stop) are write-only events and read as 0.
  - Writing start and stop together leaves the timer stopped.
- R8: The limit is at address 2 (low word) and address 3 (high word), and both read back. Writing either word zeroes the count and stops the timer.
- R9: A write to address 4 or 5 latches the full 32-bit count, whatever the write data. Address 4 then reads the low half and address 5 the high half, and both hold until the next snapshot write.
- R10: A stop write freezes the count at the value reached on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or a missed match shows up only through the snapshot words or the timeout flag. A counter that skips or stalls moves the flag away from its exact period+1 cycle, and a snapshot taken many thousands of cycles later differs in its low half. A stuck running indicator or a wrong repeat decision shows in status bit 1 on the clock right after the timeout. A lost flag shows the same clock when a clear collides with a timeout.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // register addresses
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_PLO  = 3'd2;
  localparam logic [2:0] A_PHI  = 3'd3;
  localparam logic [2:0] A_SNL  = 3'd4;
  localparam logic [2:0] A_SNH  = 3'd5;
  // control bit positions
  localparam int C_IEN   = 0;
  localparam int C_REP   = 1;
  localparam int C_START = 2;
  localparam int C_STOP  = 3;

  typedef struct packed {
    logic rep;
    logic ien;
  } ctrl_t;
endpackage

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          reload,
  input  logic          rep,
  output logic [CW-1:0] count,
  output logic          running,
  output logic          tick
);
  logic hit;
  logic run_nxt;

  assign hit  = running && (count == period);
  assign tick = hit && !reload;

  always_comb begin
    run_nxt = hit ? rep : running;
    if (stop_p)       run_nxt = 1'b0;
    else if (start_p) run_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (reload) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      if (running) count <= hit ? '0 : count + 1'b1;
      running <= run_nxt;
    end
  end
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [2*DW-1:0] RESET_PERIOD = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] count,
  input  logic            tick,
  output logic [2*DW-1:0] period,
  output ctrl_t           ctrl,
  output logic            start_p,
  output logic            stop_p,
  output logic            reload,
  output logic            flag,
  output logic [2*DW-1:0] snap
);
  localparam int unsigned NH = 2;
  logic wr_ctrl;
  logic wr_snap;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_snap = wr && (addr == A_SNL || addr == A_SNH);
  assign start_p = wr_ctrl && wdata[C_START];
  assign stop_p  = wr_ctrl && wdata[C_STOP];
  assign reload  = wr && (addr == A_PLO || addr == A_PHI);

  for (genvar h = 0; h < NH; h++) begin : g_per
    localparam logic [2:0] PADDR = A_PLO + 3'(h);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       period[h*DW +: DW] <= RESET_PERIOD[h*DW +: DW];
      else if (wr && (addr == PADDR))   period[h*DW +: DW] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      flag <= 1'b0;
      snap <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.ien <= wdata[C_IEN];
        ctrl.rep <= wdata[C_REP];
      end
      if (tick)                          flag <= 1'b1;
      else if (wr && (addr == A_STAT))   flag <= 1'b0;
      if (wr_snap) snap <= count;
    end
  end
endmodule

// File: rtl/tmr16_interval.sv
module tmr16_interval
  import tmr16_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [2*DW-1:0] RESET_PERIOD = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0] period_w;
  logic [CW-1:0] count_w;
  logic [CW-1:0] snap_w;
  ctrl_t         ctrl_w;
  logic          start_w, stop_w, reload_w, flag_w, run_w, tick_w, rep_w;

  assign rep_w = ctrl_w.rep;

  tmr16_regs #(.DW(DW), .RESET_PERIOD(RESET_PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .count(count_w), .tick(tick_w), .period(period_w), .ctrl(ctrl_w),
    .start_p(start_w), .stop_p(stop_w), .reload(reload_w), .flag(flag_w),
    .snap(snap_w)
  );

  tmr16_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .period(period_w), .start_p(start_w),
    .stop_p(stop_w), .reload(reload_w), .rep(rep_w), .count(count_w),
    .running(run_w), .tick(tick_w)
  );

  assign irq = flag_w && ctrl_w.ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT: bus_rdata = {{(DW-2){1'b0}}, run_w, flag_w};
      A_CTRL: bus_rdata = {{(DW-2){1'b0}}, ctrl_w.rep, ctrl_w.ien};
      A_PLO:  bus_rdata = period_w[DW-1:0];
      A_PHI:  bus_rdata = period_w[CW-1:DW];
      A_SNL:  bus_rdata = snap_w[DW-1:0];
      A_SNH:  bus_rdata = snap_w[CW-1:DW];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_interval_chk.sv
module tmr16_interval_chk
  import tmr16_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [2:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [2*DW-1:0] count,
  input logic [2*DW-1:0] period,
  input logic [2*DW-1:0] snap,
  input logic            running,
  input logic            flag,
  input logic            rep
);
  logic wr_per, wr_snap, start_w, stop_w, hit;
  assign wr_per  = bus_wr && (bus_addr == A_PLO || bus_addr == A_PHI);
  assign wr_snap = bus_wr && (bus_addr == A_SNL || bus_addr == A_SNH);
  assign stop_w  = bus_wr && (bus_addr == A_CTRL) && bus_wdata[C_STOP];
  assign start_w = bus_wr && (bus_addr == A_CTRL) && bus_wdata[C_START] && !bus_wdata[C_STOP];
  assign hit     = running && (count == period);

  assert_period_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per |=> (count == '0) && !running);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running && !wr_per && !hit |=> count == $past(count) + 1'b1);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !wr_per |=> $stable(count));
  assert_single_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !rep && !wr_per && !start_w |=> !running);
  assert_repeat_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && rep && !wr_per && !stop_w |=> running && (count == '0));
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wr_per |=> flag);
  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_snap |=> $stable(snap));
endmodule

bind tmr16_interval tmr16_interval_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .count(count_w), .period(period_w), .snap(snap_w),
  .running(run_w), .flag(flag_w), .rep(rep_w)
);

// File: tb/sim_tmr16_interval.sv
module sim_tmr16_interval;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {write, addr, data, expected, req}
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 3'd2, 16'h1234, 16'h0000, 4'd8},  // R8 limit low
    {1'b1, 3'd3, 16'hABCD, 16'h0000, 4'd8},  // R8 limit high
    {1'b0, 3'd2, 16'h0000, 16'h1234, 4'd8},  // R8
    {1'b0, 3'd3, 16'h0000, 16'hABCD, 4'd8},  // R8
    {1'b0, 3'd0, 16'h0000, 16'h0000, 4'd8},  // R8 stopped
    {1'b1, 3'd1, 16'h0003, 16'h0000, 4'd7},  // R7
    {1'b0, 3'd1, 16'h0000, 16'h0003, 4'd7},  // R7
    {1'b1, 3'd1, 16'h000F, 16'h0000, 4'd7},  // R7 start+stop
    {1'b0, 3'd0, 16'h0000, 16'h0000, 4'd7},  // R7 stop wins
    {1'b0, 3'd1, 16'h0000, 16'h0003, 4'd7},  // R7 events read 0
    {1'b1, 3'd1, 16'h0000, 16'h0000, 4'd7},  // R7
    {1'b0, 3'd1, 16'h0000, 16'h0000, 4'd7},  // R7
    {1'b1, 3'd4, 16'h5A5A, 16'h0000, 4'd9},  // R9 snap
    {1'b0, 3'd4, 16'h0000, 16'h0000, 4'd9},  // R9
    {1'b0, 3'd5, 16'h0000, 16'h0000, 4'd9}   // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] v;

  tmr16_interval u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] r);
    bus_addr = a;
    #1;
    r = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(3'd0, v); chk("R1 status", v, 16'h0000);
    peek(3'd1, v); chk("R1 control", v, 16'h0000);
    peek(3'd2, v); chk("R1 limit low", v, 16'hFFFF);
    peek(3'd3, v); chk("R1 limit high", v, 16'hFFFF);
    peek(3'd4, v); chk("R1 snap low", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39]) wr_reg(VEC[i][38:36], VEC[i][35:20]);
      else begin
        peek(VEC[i][38:36], v);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
      end
    end

    // single mode with interrupt, limit 3: R2 R4 R5
    wr_reg(3'd2, 16'd3);
    wr_reg(3'd3, 16'd0);
    wr_reg(3'd1, 16'h0005);
    repeat (3) @(negedge clk);
    peek(3'd0, v); chk("R2 no timeout before period+1", v, 16'h0002);
    chk("R5 irq low before timeout", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    peek(3'd0, v); chk("R4 timeout halts", v, 16'h0001);
    chk("R5 irq high", {15'b0, irq}, 16'h0001);
    wr_reg(3'd5, 16'h0000);
    peek(3'd4, v); chk("R4 count zero", v, 16'h0000);
    wr_reg(3'd0, 16'h0000);
    peek(3'd0, v); chk("R6 clear", v, 16'h0000);
    chk("R5 irq drops", {15'b0, irq}, 16'h0000);

    // repeating mode without interrupt: R3 R5 R6
    wr_reg(3'd1, 16'h0006);
    repeat (4) @(negedge clk);
    peek(3'd0, v); chk("R3 first timeout, still running", v, 16'h0003);
    chk("R5 irq masked", {15'b0, irq}, 16'h0000);
    wr_reg(3'd0, 16'h0000);
    peek(3'd0, v); chk("R6 cleared", v, 16'h0002);
    @(negedge clk);
    peek(3'd0, v); chk("R3 not yet", v, 16'h0002);
    @(negedge clk);
    peek(3'd0, v); chk("R3 second timeout", v, 16'h0003);
    repeat (2) @(negedge clk);
    wr_reg(3'd0, 16'h0000);   // lands on the third timeout edge
    peek(3'd0, v); chk("R6 set wins", v, 16'h0003);
    peek(3'd1, v); chk("R7 control readback", v, 16'h0002);

    // limit write while running: R8 R9
    wr_reg(3'd2, 16'd3);
    peek(3'd0, v); chk("R8 stopped by limit write", v, 16'h0001);
    wr_reg(3'd5, 16'hFFFF);
    peek(3'd4, v); chk("R8 count reloaded", v, 16'h0000);
    peek(3'd5, v); chk("R9 data ignored", v, 16'h0000);
    wr_reg(3'd0, 16'h0000);

    // coherent snapshot across the half boundary: R9 R2
    wr_reg(3'd2, 16'h0000);
    wr_reg(3'd3, 16'h0002);
    wr_reg(3'd1, 16'h0004);
    repeat (69999) @(negedge clk);
    wr_reg(3'd4, 16'h0000);
    peek(3'd5, v); chk("R9 snap high", v, 16'h0001);
    peek(3'd4, v); chk("R2 R9 snap low", v, 16'h1170);
    repeat (10) @(negedge clk);
    peek(3'd4, v); chk("R9 snap held", v, 16'h1170);
    wr_reg(3'd5, 16'h0000);
    peek(3'd4, v); chk("R9 snap via high word", v, 16'h117C);

    // stop freezes: R10
    wr_reg(3'd1, 16'h0008);
    wr_reg(3'd4, 16'h0000);
    peek(3'd4, v); chk("R10 frozen value", v, 16'h117F);
    repeat (5) @(negedge clk);
    wr_reg(3'd4, 16'h0000);
    peek(3'd4, v); chk("R10 still frozen", v, 16'h117F);
    peek(3'd5, v); chk("R10 high word", v, 16'h0001);
    wr_reg(3'd1, 16'h0004);
    peek(3'd0, v); chk("R7 start resumes", v, 16'h0002);

    finish_run();
  end
endmodule